// File: doc/BRIEF.md
# SMBus Indexed Configuration Register Target

This block is a target-only two-wire serial bus device. It holds the configuration bytes of a multi-output clock generator and gives the rest of the chip a flat, parallel copy of all of them. It answers one fixed 7-bit device address. It never starts a transfer of its own. SCL and SDA come in from the pads through flop synchronizers. The block drives SDA only through an open-drain enable, which pulls the line low when set.

A host writes by sending the address byte (D2h), a register offset, a byte count and then the data bytes. The internal pointer moves up by one after every data byte. To read, the host writes the offset and issues a repeated start with the read form of the address (D3h). The target then returns bytes from the pointer onward, moving the pointer after each byte, until the host answers a byte with NACK.

One byte of the bank is a read-only status byte. It holds strap input levels that are captured on the first clock after power-good rises and never change afterwards. One bit of another byte is reserved. The synchronous active-low reset is the power-good signal. Deasserting it returns every control byte to its default.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset, `sda_oe` is 0, byte 1 reads F7h, every other control byte reads FFh, and the status byte (index 6) holds the captured strap value.
- R2: Only an address byte whose upper seven bits are 69h is acknowledged. The target ignores any other address and all bytes that follow it until the next start, and it writes nothing.
- R3: In a write, the target acknowledges the address, the offset, the byte count and each counted data byte. Each data byte is stored at the pointer, and the pointer then moves up by one.
- R4: Once the number of data bytes given by the count has been written, the target does not acknowledge further data bytes and does not store them.
- R5: Bit 3 of byte 1 is reserved. A write to it is ignored and it always reads as 0.
- R6: Byte 6 is read-only. Writes to it are ignored, bits 2:0 hold the strap value and bits 7:3 read as 0.
- R7: The strap inputs are sampled on the first clock with reset high. Later changes on the strap inputs have no effect until the next reset.
- R8: After an offset write and a repeated start with address D3h, the target returns the byte at the pointer, MSB first, then the following bytes in order.
- R9: When the host answers a read byte with NACK, the target ends the transfer and leaves SDA released.
- R10: The offset and the pointer are taken modulo the bank size (8). Offset 9 selects byte 1, and a read past byte 7 continues at byte 0.
- R11: A stop condition ends any transfer, including one cut short before its count runs out. The next transfer starts fresh. The target changes its SDA drive only while SCL is low.
- R12: Deasserting power-good (reset low) at any time restores every control byte to its default and captures the straps again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, much faster than SCL |
| rst_n | input | 1 | Power-good, synchronous active-low reset |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad |
| strap_i | input | NSTRAP | Strap pin levels captured after power-good |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| cfg_o | output | NREG*8 | All register bytes; byte k at bits 8k+7:8k |

## Verification
The assertions assume a well-behaved host. It changes SDA only while SCL is low, except at start and stop conditions. It holds each SCL level for more cycles than the synchronizer delay, and it issues a stop only after the target has let go of SDA. The bench master keeps to this. It splits every SCL period into four quarters of ten clocks, changes SDA one quarter after the falling edge, and samples one quarter after the rising edge. As a result, the check that the drive changes only while SCL is low relates the raw pin to the target's reaction. The read-only and reserved-bit properties hold on every cycle regardless of the traffic.

// File: rtl/smb_cfg_pkg.sv
`timescale 1ns/1ps
// Shared types and the per-byte write mask for the configuration target.
// Assumes byte-wide registers; the mask also serves as the reset default.
package smb_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_SACK, ST_TX, ST_MACK
    } smb_state_e;

    typedef enum logic [1:0] {
        RL_ADDR, RL_OFFS, RL_CNT, RL_DATA
    } smb_role_e;

    // Writable bits of byte idx: none for the status byte, all but one reserved bit elsewhere.
    function automatic logic [7:0] byte_mask(int idx, int stat_idx, int rsv_idx, int rsv_bit);
        logic [7:0] m;
        m = 8'hFF;
        if (idx == rsv_idx) m = m & ~(8'h01 << rsv_bit);
        if (idx == stat_idx) m = 8'h00;
        return m;
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
`timescale 1ns/1ps
// Brings SCL and SDA into the clock domain and flags edges and bus conditions.
// Assumes the core clock samples each SCL level several times.
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES:0] scl_p;
    logic [STAGES:0] sda_p;

    // Synchronizer chains plus one history stage; idle bus reads high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[STAGES-1:0], scl_i};
            sda_p <= {sda_p[STAGES-1:0], sda_i};
        end
    end

    // Edge and condition decode on the synchronized levels.
    always_comb begin
        sda_s     = sda_p[STAGES-1];
        scl_rise  = scl_p[STAGES-1] & ~scl_p[STAGES];
        scl_fall  = ~scl_p[STAGES-1] & scl_p[STAGES];
        start_det = scl_p[STAGES-1] & scl_p[STAGES] & sda_p[STAGES] & ~sda_p[STAGES-1];
        stop_det  = scl_p[STAGES-1] & scl_p[STAGES] & ~sda_p[STAGES] & sda_p[STAGES-1];
    end
endmodule

// File: rtl/smb_cfg_proto.sv
`timescale 1ns/1ps
// Byte-level sequencer: address match, offset, count, data write, read-out
// and acknowledge handling. Assumes NREG is a power of two (pointer wraps).
module smb_cfg_proto import smb_cfg_pkg::*; #(
    parameter int          NREG     = 8,
    parameter logic [6:0]  DEV_ADDR = 7'h69,
    localparam int         AW       = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] rd_idx,
    output logic          wr_en,
    output logic [AW-1:0] wr_idx,
    output logic [7:0]    wr_data,
    output logic          sda_oe
);
    smb_state_e    st;
    smb_role_e     role;
    logic [3:0]    bitcnt;
    logic [7:0]    shreg;
    logic [AW-1:0] ptr;
    logic [7:0]    remain;
    logic          go_tx;
    logic          more;

    assign rd_idx = ptr;

    // Protocol state machine; bus conditions take priority over bit events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            role    <= RL_ADDR;
            bitcnt  <= '0;
            shreg   <= '0;
            ptr     <= '0;
            remain  <= '0;
            go_tx   <= 1'b0;
            more    <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
            sda_oe  <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                st     <= ST_RX;
                role   <= RL_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            st     <= ST_SACK;
                            sda_oe <= 1'b1;
                            go_tx  <= 1'b0;
                            case (role)
                                RL_ADDR: begin
                                    if (shreg[7:1] == DEV_ADDR) begin
                                        go_tx <= shreg[0];
                                        role  <= RL_OFFS;
                                    end else begin
                                        st     <= ST_IDLE;
                                        sda_oe <= 1'b0;
                                    end
                                end
                                RL_OFFS: begin
                                    ptr  <= shreg[AW-1:0];
                                    role <= RL_CNT;
                                end
                                RL_CNT: begin
                                    remain <= shreg;
                                    role   <= RL_DATA;
                                end
                                default: begin
                                    if (remain != 8'd0) begin
                                        wr_en   <= 1'b1;
                                        wr_idx  <= ptr;
                                        wr_data <= shreg;
                                        ptr     <= ptr + AW'(1);
                                        remain  <= remain - 8'd1;
                                    end else begin
                                        sda_oe <= 1'b0;
                                    end
                                end
                            endcase
                        end
                    end
                    ST_SACK: begin
                        if (scl_fall) begin
                            if (go_tx) begin
                                shreg  <= rd_data;
                                ptr    <= ptr + AW'(1);
                                sda_oe <= ~rd_data[7];
                                st     <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                bitcnt <= '0;
                                sda_oe <= 1'b0;
                                st     <= ST_MACK;
                            end else begin
                                bitcnt <= bitcnt + 4'd1;
                                shreg  <= {shreg[6:0], 1'b0};
                                sda_oe <= ~shreg[6];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            more <= ~sda_s;
                        end else if (scl_fall) begin
                            if (more) begin
                                shreg  <= rd_data;
                                ptr    <= ptr + AW'(1);
                                sda_oe <= ~rd_data[7];
                                st     <= ST_TX;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/smb_cfg_regs.sv
`timescale 1ns/1ps
// Register bank: masked writable bytes, one read-only strap status byte.
// Assumes the strap inputs are stable around the release of power-good.
module smb_cfg_regs import smb_cfg_pkg::*; #(
    parameter int  NREG     = 8,
    parameter int  STAT_IDX = 6,
    parameter int  RSV_IDX  = 1,
    parameter int  RSV_BIT  = 3,
    parameter int  NSTRAP   = 3,
    localparam int AW       = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSTRAP-1:0] strap_i,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [AW-1:0]     rd_idx,
    output logic [7:0]        rd_data,
    output logic [NREG*8-1:0] cfg_o
);
    logic [NSTRAP-1:0] strap_q;
    logic              cap_done;

    // One-shot strap capture on the first cycle after power-good.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_q  <= '0;
            cap_done <= 1'b0;
        end else if (!cap_done) begin
            strap_q  <= strap_i;
            cap_done <= 1'b1;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_byte
        if (g == STAT_IDX) begin : g_stat
            assign cfg_o[g*8 +: 8] = {{(8-NSTRAP){1'b0}}, strap_q};
        end else begin : g_rw
            localparam logic [7:0] M = byte_mask(g, STAT_IDX, RSV_IDX, RSV_BIT);
            logic [7:0] q;
            // Masked byte store; reserved bits never leave zero.
            always_ff @(posedge clk) begin
                if (!rst_n)                            q <= M;
                else if (wr_en && wr_idx == AW'(g))    q <= wr_data & M;
            end
            assign cfg_o[g*8 +: 8] = q;
        end
    end

    assign rd_data = cfg_o[{rd_idx, 3'b000} +: 8];
endmodule

// File: rtl/smb_cfg_slave.sv
`timescale 1ns/1ps
// Top: SMBus-style target holding the clock generator configuration bytes.
// Assumes an external open-drain pad that pulls SDA low while sda_oe is 1.
module smb_cfg_slave #(
    parameter int         NREG        = 8,
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         STAT_IDX    = 6,
    parameter int         RSV_IDX     = 1,
    parameter int         RSV_BIT     = 3,
    parameter int         NSTRAP      = 3,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [NSTRAP-1:0] strap_i,
    output logic              sda_oe,
    output logic [NREG*8-1:0] cfg_o
);
    localparam int AW = $clog2(NREG);

    logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic          wr_en;
    logic [AW-1:0] wr_idx, rd_idx;
    logic [7:0]    wr_data, rd_data;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smb_cfg_proto #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_proto (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .sda_oe(sda_oe)
    );

    smb_cfg_regs #(
        .NREG(NREG), .STAT_IDX(STAT_IDX), .RSV_IDX(RSV_IDX),
        .RSV_BIT(RSV_BIT), .NSTRAP(NSTRAP)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
        .rd_data(rd_data), .cfg_o(cfg_o)
    );
endmodule

// File: rtl/smb_cfg_chk.sv
`timescale 1ns/1ps
// Property checker for smb_cfg_slave, attached by bind below.
// Assumes the host changes SDA only while SCL is low (except start/stop).
module smb_cfg_chk import smb_cfg_pkg::*; #(
    parameter int NREG     = 8,
    parameter int STAT_IDX = 6,
    parameter int RSV_IDX  = 1,
    parameter int RSV_BIT  = 3,
    parameter int NSTRAP   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic [NREG*8-1:0] cfg_o
);
    // R11: drive changes only land while the raw clock line is low.
    p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_i);

    // R5: reserved bit stays clear.
    p_rsv_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_o[RSV_IDX*8 + RSV_BIT] == 1'b0);

    // R6: status byte upper bits stay clear.
    p_stat_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_o[STAT_IDX*8 + 7 : STAT_IDX*8 + NSTRAP] == '0);

    // R7: status byte frozen once captured.
    p_stat_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> $stable(cfg_o[STAT_IDX*8 +: 8]));

    for (genvar g = 0; g < NREG; g++) begin : g_dflt
        if (g != STAT_IDX) begin : g_ctl
            // R12: each control byte holds its default on leaving reset.
            p_reset_dflt_r12: assert property (@(posedge clk) disable iff (!rst_n)
                !$past(rst_n) |-> cfg_o[g*8 +: 8] == byte_mask(g, STAT_IDX, RSV_IDX, RSV_BIT));
        end
    end
endmodule

bind smb_cfg_slave smb_cfg_chk #(
    .NREG(NREG), .STAT_IDX(STAT_IDX), .RSV_IDX(RSV_IDX),
    .RSV_BIT(RSV_BIT), .NSTRAP(NSTRAP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .cfg_o(cfg_o)
);

// File: tb/sim_smb_cfg_slave.sv
`timescale 1ns/1ps
// Bench: open-drain bus model, bit-level master tasks, vector loop, directed tests.
module sim_smb_cfg_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;
    localparam int WD_CYCLES  = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic [2:0]  strap = 3'b101;
    logic        sda_oe;
    logic [63:0] cfg;
    wire         sda_line = sda_m & ~sda_oe;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] rbuf [0:3];

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_cfg_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .strap_i(strap), .sda_oe(sda_oe), .cfg_o(cfg)
    );

    // {offset, written data, expected readback}
    localparam logic [23:0] VEC [0:5] = '{
        24'h00_A5_A5,   // R3 plain byte
        24'h01_FF_F7,   // R5 reserved bit dropped
        24'h06_FF_05,   // R6 status byte keeps strap
        24'h07_3C_3C,   // R3 last byte
        24'h09_08_00,   // R10 wraps to byte 1, R5 bit 3
        24'h02_00_00    // R3 clear a byte
    };

    task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] cbyte(input int i);
        return cfg[i*8 +: 8];
    endfunction

    task automatic wq;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wq; scl = 1'b1; wq; wq; scl = 1'b0; wq;
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; wq; scl = 1'b1; wq; b = sda_line; wq; scl = 1'b0; wq;
    endtask

    task automatic bstart;
        sda_m = 1'b1; wq; scl = 1'b1; wq; sda_m = 1'b0; wq; scl = 1'b0; wq;
    endtask

    task automatic bstop;
        sda_m = 1'b0; wq; scl = 1'b1; wq; sda_m = 1'b1; wq;
    endtask

    task automatic send(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(b);
        ack = ~b;
    endtask

    task automatic recv(input logic ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) bit_in(d[i]);
        bit_out(~ack);
    endtask

    task automatic wr1(input logic [7:0] offs, input logic [7:0] d, output logic ok);
        logic a0, a1, a2, a3;
        bstart; send(8'hD2, a0); send(offs, a1); send(8'h01, a2); send(d, a3); bstop;
        ok = a0 & a1 & a2 & a3;
    endtask

    // Indexed read of n bytes, last one NACKed; caller issues the stop.
    task automatic rdn(input logic [7:0] offs, input int n, output logic ok);
        logic a0, a1, a2;
        bstart; send(8'hD2, a0); send(offs, a1);
        bstart; send(8'hD3, a2);
        for (int k = 0; k < n; k++) recv(k != n - 1, rbuf[k]);
        ok = a0 & a1 & a2;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic ok, a;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        chk8("R1 sda_oe", {7'd0, sda_oe}, 8'h00);
        for (int i = 0; i < 8; i++)
            chk8("R1 default byte", cbyte(i), (i == 1) ? 8'hF7 : (i == 6) ? 8'h05 : 8'hFF);

        // Vector loop: write one byte, check parallel copy and bus readback
        for (int v = 0; v < 6; v++) begin
            wr1(VEC[v][23:16], VEC[v][15:8], ok);
            chk8("R3 write acks", {7'd0, ok}, 8'h01);
            chk8("R3 stored byte", cbyte(int'(VEC[v][18:16])), VEC[v][7:0]);
            rdn(VEC[v][23:16], 1, ok);
            bstop;
            chk8("R8 read acks", {7'd0, ok}, 8'h01);
            chk8("R8 read byte", rbuf[0], VEC[v][7:0]);
        end

        // R2 foreign address: no ack, nothing written
        bstart; send(8'hA0, a);
        chk8("R2 foreign addr ack", {7'd0, a}, 8'h00);
        send(8'h00, a); send(8'h01, a); send(8'h11, a); bstop;
        chk8("R2 byte0 untouched", cbyte(0), 8'hA5);

        // R3/R4 multi-byte write with count 2 and one extra byte
        bstart; send(8'hD2, a); send(8'h03, a); send(8'h02, a);
        send(8'h11, a); chk8("R3 data ack 1", {7'd0, a}, 8'h01);
        send(8'h22, a); chk8("R3 data ack 2", {7'd0, a}, 8'h01);
        send(8'h99, a); chk8("R4 extra byte nack", {7'd0, a}, 8'h00);
        bstop;
        chk8("R3 byte3", cbyte(3), 8'h11);
        chk8("R3 byte4", cbyte(4), 8'h22);
        chk8("R4 byte5 untouched", cbyte(5), 8'hFF);

        // R8/R10/R9 burst read from 6 wrapping to 0, NACK ends it
        rdn(8'h06, 3, ok);
        chk8("R8 burst acks", {7'd0, ok}, 8'h01);
        chk8("R8 burst b6", rbuf[0], 8'h05);
        chk8("R8 burst b7", rbuf[1], 8'h3C);
        chk8("R10 burst wrap b0", rbuf[2], 8'hA5);
        wq; wq;
        chk8("R9 released after nack", {7'd0, sda_oe}, 8'h00);
        chk8("R9 line high", {7'd0, sda_line}, 8'h01);
        bstop;

        // R11 stop before count runs out, then a fresh transfer
        bstart; send(8'hD2, a); send(8'h03, a); send(8'h03, a); send(8'h5A, a); bstop;
        chk8("R11 partial byte3", cbyte(3), 8'h5A);
        chk8("R11 byte4 untouched", cbyte(4), 8'h22);
        wr1(8'h00, 8'h77, ok);
        chk8("R11 fresh acks", {7'd0, ok}, 8'h01);
        chk8("R11 fresh byte0", cbyte(0), 8'h77);

        // R7 strap change after capture has no effect
        strap = 3'b010;
        repeat (8) @(negedge clk);
        chk8("R7 status held", cbyte(6), 8'h05);
        rdn(8'h06, 1, ok); bstop;
        chk8("R7 status via bus", rbuf[0], 8'h05);

        // R12 power-good drop restores defaults and recaptures straps
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 8; i++)
            chk8("R12 default byte", cbyte(i), (i == 1) ? 8'hF7 : (i == 6) ? 8'h02 : 8'hFF);
        chk8("R12 sda_oe", {7'd0, sda_oe}, 8'h00);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule